// File: doc/BRIEF.md
# SPI Sector-Transfer Polling Master

This block is an SPI master that serves a slave which asks for whole 512-byte sectors to be moved. A prescaler started from the system clock asks the slave for its status ten times a second. Each status frame carries a 24-bit sector number and two request flags. The master reports every change of that 32-bit status word. It then either reads the sector from local storage and streams it to the slave, or pulls a sector out of the slave and passes it to storage.

Storage is reached through three interfaces. The first is a fetch handshake that names the sector and reports success or an error. The second is a byte source for data going to the slave. The third is a byte sink for data coming from the slave. The SPI link runs in mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge, and the most significant bit goes first. Select is released between every two transactions so that the slave can clear its framing.

Top module: `spi_sector_poller`

## Requirements
- R1: While no transfer is in progress, a status poll starts every CLK_HZ/POLL_HZ clock cycles. The cycle count between two consecutive poll starts with only polls in between is exactly that value.
- R2: A poll drives select low, sends command byte 0x50, clocks in four response bytes and drives select high again. All bytes use SPI mode 0 with the most significant bit first.
- R3: At the end of a poll, status_word holds the four response bytes with the first one in bits 31:24. Bits 31:8 are the sector number, most significant byte first.
- R4: status_chg is high for exactly one cycle, the cycle in which select returns high after a poll. It is raised only when the new status_word differs from the previous one. The value before the first poll is zero.
- R5: The last status byte is decoded only when its bits 7:2 equal 101001. Bit 0 then requests a read toward the slave and bit 1 requests a write from the slave, and a read wins when both bits are set. With a bad signature or neither bit set, the master does no transfer and waits for the next poll.
- R6: For a read request, fetch_req rises while select is high and stays high with xfer_sector stable until fetch_ack. When fetch_err is high together with fetch_ack, the 0x51 transfer is skipped.
- R7: After a successful fetch, the master sends command 0x51 followed by 512 bytes taken from the source port in order. A byte is taken on each cycle where src_valid and src_ready are both high.
- R8: For a write request, the master sends command 0x52 and then clocks in 512 bytes. Each byte is offered on snk_data with snk_valid held until snk_ready, and the bytes keep the order of arrival.
- R9: Select stays high for at least CS_GAP cycles between any two transactions, and SCLK is low whenever select is high.
- R10: After reset, select is high, SCLK and MOSI are low, and fetch_req, snk_valid, status_chg and status_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_cs_n | output | 1 | Slave select, active low |
| fetch_req | output | 1 | Ask storage to load the sector named by xfer_sector |
| fetch_ack | input | 1 | Storage finished the fetch |
| fetch_err | input | 1 | Fetch failed; valid with fetch_ack |
| xfer_sector | output | 24 | Sector of the request being served |
| src_data | input | 8 | Sector byte from storage |
| src_valid | input | 1 | src_data holds a byte |
| src_ready | output | 1 | Master can take a source byte |
| snk_data | output | 8 | Byte received from the slave |
| snk_valid | output | 1 | snk_data holds a byte |
| snk_ready | input | 1 | Storage takes the sink byte |
| status_word | output | 32 | Status from the most recent poll |
| status_chg | output | 1 | One-cycle pulse when the status changed |

## Verification
The hardest situation to reach is a poll that follows a failed fetch. The error path leaves no trace on the pins except the absence of a 0x51 command, so the bench has to script it. A behavioural slave answers each poll from a fixed status script, and the storage model returns an error on the first read request only. The bench then predicts the next command byte the slave should see (0x50 again, followed by a retried read) and compares it on the wire. The same script covers both request bits set, a bad signature word, and stalled source and sink handshakes during the 512-byte streams.

// File: rtl/spi_sector_pkg.sv
// Shared constants and the sequencer state type for the SPI sector poller.
// Assumes: single clock domain, SPI slave framing reset by high select.
package spi_sector_pkg;

    localparam logic [7:0] CMD_STATUS   = 8'h50;
    localparam logic [7:0] CMD_TO_SLAVE = 8'h51;
    localparam logic [7:0] CMD_FROM_SLV = 8'h52;
    localparam logic [5:0] STATUS_SIG   = 6'b101001;
    localparam int         RESP_BYTES   = 4;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_POLL,
        SQ_DECIDE,
        SQ_FETCH,
        SQ_WAIT_RD,
        SQ_RD_CMD,
        SQ_RD_NEED,
        SQ_RD_SHIFT,
        SQ_WAIT_WR,
        SQ_WR_CMD,
        SQ_WR_SHIFT,
        SQ_WR_HAND
    } seq_state_t;

endpackage

// File: rtl/sp_poll_timer.sv
// Poll prescaler: emits a one-cycle tick every PERIOD clock cycles.
// Assumes: PERIOD >= 2; the first tick comes PERIOD cycles after reset.
module sp_poll_timer #(
    parameter int PERIOD = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Wrap the counter and flag each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R1
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sp_byte_shifter.sv
// SPI mode-0 byte shifter: on start it shifts out tx MSB first while it
// samples MISO on each rising SCLK edge, then pulses done with the received byte.
// Assumes: start is given only while the shifter is idle; select is
// handled by the caller.
module sp_byte_shifter #(
    parameter int SCK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(SCK_HALF - 1);

    logic          busy;
    logic [HW-1:0] half_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    // Step through the low and high SCLK phases of eight bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            half_cnt <= '0;
            bit_idx  <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            sclk     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    sh_tx    <= tx;
                    half_cnt <= '0;
                    bit_idx  <= '0;
                    sclk     <= 1'b0;
                end
            end else if (half_cnt == HALF_LAST) begin
                half_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                    end
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // Present the current bit only while a byte is in flight.
    always_comb begin
        mosi = busy ? sh_tx[7] : 1'b0;
        rx   = sh_rx;
    end

    // R2
    // A byte ends on a falling SCLK edge.
    byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sclk && $past(sclk)));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sp_sequencer.sv
// Transaction sequencer: runs status polls, decodes the status word and
// drives the fetch, 0x51 read-out and 0x52 write-in transactions.
// Assumes: the byte shifter accepts start only when idle and pulses done
// once per byte; storage handshakes follow valid/ready rules.
module sp_sequencer
    import spi_sector_pkg::*;
#(
    parameter int CS_GAP       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        poll_tick,
    output logic        eng_start,
    output logic [7:0]  eng_tx,
    input  logic        eng_done,
    input  logic [7:0]  eng_rx,
    output logic        cs_n,
    output logic        fetch_req,
    input  logic        fetch_ack,
    input  logic        fetch_err,
    output logic [23:0] xfer_sector,
    input  logic [7:0]  src_data,
    input  logic        src_valid,
    output logic        src_ready,
    output logic [7:0]  snk_data,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [31:0] status_word,
    output logic        status_chg
);
    localparam int GW   = $clog2(CS_GAP + 1);
    localparam int IDXW = $clog2(SECTOR_BYTES);
    localparam logic [GW-1:0]   GAP_DONE = GW'(CS_GAP);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(SECTOR_BYTES - 1);
    localparam logic [IDXW-1:0] RESP_END = IDXW'(RESP_BYTES);

    seq_state_t    state;
    logic          poll_pend;
    logic [GW-1:0] hi_cnt;
    logic          gap_ok;
    logic [IDXW-1:0] byte_idx;
    logic [23:0]   sh_word;
    logic [31:0]   new_word;
    logic          sig_ok;
    logic          want_rd;
    logic          want_wr;

    // Decode the latest status word and form the word being assembled.
    always_comb begin
        gap_ok    = (hi_cnt == GAP_DONE);
        new_word  = {sh_word, eng_rx};
        sig_ok    = (status_word[7:2] == STATUS_SIG);
        want_rd   = sig_ok && status_word[0];
        want_wr   = sig_ok && status_word[1];
        src_ready = (state == SQ_RD_NEED);
    end

    // Count cycles of high select, saturating at CS_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (!gap_ok) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Remember a poll tick until a poll can start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_pend <= 1'b0;
        end else if (state == SQ_IDLE && poll_pend && gap_ok) begin
            poll_pend <= poll_tick;
        end else if (poll_tick) begin
            poll_pend <= 1'b1;
        end
    end

    // Main transaction state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            cs_n        <= 1'b1;
            eng_start   <= 1'b0;
            eng_tx      <= '0;
            byte_idx    <= '0;
            sh_word     <= '0;
            status_word <= '0;
            status_chg  <= 1'b0;
            fetch_req   <= 1'b0;
            xfer_sector <= '0;
            snk_data    <= '0;
            snk_valid   <= 1'b0;
        end else begin
            eng_start  <= 1'b0;
            status_chg <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (poll_pend && gap_ok) begin
                        cs_n      <= 1'b0;
                        eng_start <= 1'b1;
                        eng_tx    <= CMD_STATUS;
                        byte_idx  <= '0;
                        state     <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (eng_done) begin
                        if (byte_idx != '0) begin
                            sh_word <= new_word[23:0];
                        end
                        if (byte_idx == RESP_END) begin
                            cs_n        <= 1'b1;
                            status_word <= new_word;
                            status_chg  <= (new_word != status_word);
                            state       <= SQ_DECIDE;
                        end else begin
                            byte_idx  <= byte_idx + 1'b1;
                            eng_start <= 1'b1;
                            eng_tx    <= 8'h00;
                        end
                    end
                end
                SQ_DECIDE: begin
                    if (want_rd || want_wr) begin
                        xfer_sector <= status_word[31:8];
                    end
                    if (want_rd) begin
                        fetch_req <= 1'b1;
                        state     <= SQ_FETCH;
                    end else if (want_wr) begin
                        state <= SQ_WAIT_WR;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                SQ_FETCH: begin
                    if (fetch_ack) begin
                        fetch_req <= 1'b0;
                        state     <= fetch_err ? SQ_IDLE : SQ_WAIT_RD;
                    end
                end
                SQ_WAIT_RD: begin
                    if (gap_ok) begin
                        cs_n      <= 1'b0;
                        eng_start <= 1'b1;
                        eng_tx    <= CMD_TO_SLAVE;
                        state     <= SQ_RD_CMD;
                    end
                end
                SQ_RD_CMD: begin
                    if (eng_done) begin
                        byte_idx <= '0;
                        state    <= SQ_RD_NEED;
                    end
                end
                SQ_RD_NEED: begin
                    if (src_valid) begin
                        eng_start <= 1'b1;
                        eng_tx    <= src_data;
                        state     <= SQ_RD_SHIFT;
                    end
                end
                SQ_RD_SHIFT: begin
                    if (eng_done) begin
                        if (byte_idx == LAST_IDX) begin
                            cs_n  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= SQ_RD_NEED;
                        end
                    end
                end
                SQ_WAIT_WR: begin
                    if (gap_ok) begin
                        cs_n      <= 1'b0;
                        eng_start <= 1'b1;
                        eng_tx    <= CMD_FROM_SLV;
                        state     <= SQ_WR_CMD;
                    end
                end
                SQ_WR_CMD: begin
                    if (eng_done) begin
                        byte_idx  <= '0;
                        eng_start <= 1'b1;
                        eng_tx    <= 8'h00;
                        state     <= SQ_WR_SHIFT;
                    end
                end
                SQ_WR_SHIFT: begin
                    if (eng_done) begin
                        snk_data  <= eng_rx;
                        snk_valid <= 1'b1;
                        state     <= SQ_WR_HAND;
                    end
                end
                SQ_WR_HAND: begin
                    if (snk_ready) begin
                        snk_valid <= 1'b0;
                        if (byte_idx == LAST_IDX) begin
                            cs_n  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            byte_idx  <= byte_idx + 1'b1;
                            eng_start <= 1'b1;
                            eng_tx    <= 8'h00;
                            state     <= SQ_WR_SHIFT;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R4
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |=> !status_chg);
    // R4
    chg_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |-> $rose(cs_n));
    // R6
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(xfer_sector)));
    // R6
    fetch_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> cs_n);
    // R8
    snk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

endmodule

// File: rtl/spi_sector_poller.sv
// Top of the SPI sector-transfer polling master: joins the poll prescaler,
// the mode-0 byte shifter and the transaction sequencer.
// Assumes: CLK_HZ/POLL_HZ >= 2 and SCK_HALF clock cycles per SCLK phase.
module spi_sector_poller #(
    parameter int CLK_HZ       = 50_000_000,
    parameter int POLL_HZ      = 10,
    parameter int SCK_HALF     = 4,
    parameter int CS_GAP       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        fetch_req,
    input  logic        fetch_ack,
    input  logic        fetch_err,
    output logic [23:0] xfer_sector,
    input  logic [7:0]  src_data,
    input  logic        src_valid,
    output logic        src_ready,
    output logic [7:0]  snk_data,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [31:0] status_word,
    output logic        status_chg
);
    localparam int POLL_CYCLES = CLK_HZ / POLL_HZ;

    logic       poll_tick;
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    sp_poll_timer #(.PERIOD(POLL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (poll_tick)
    );

    sp_byte_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .tx    (eng_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (eng_done),
        .rx    (eng_rx)
    );

    sp_sequencer #(.CS_GAP(CS_GAP), .SECTOR_BYTES(SECTOR_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_tick   (poll_tick),
        .eng_start   (eng_start),
        .eng_tx      (eng_tx),
        .eng_done    (eng_done),
        .eng_rx      (eng_rx),
        .cs_n        (spi_cs_n),
        .fetch_req   (fetch_req),
        .fetch_ack   (fetch_ack),
        .fetch_err   (fetch_err),
        .xfer_sector (xfer_sector),
        .src_data    (src_data),
        .src_valid   (src_valid),
        .src_ready   (src_ready),
        .snk_data    (snk_data),
        .snk_valid   (snk_valid),
        .snk_ready   (snk_ready),
        .status_word (status_word),
        .status_chg  (status_chg)
    );

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R2
    mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

endmodule

// File: tb/spi_sector_poller_test.sv
// Bench: behavioural SPI slave, storage models and a per-clock reference
// of the expected command sequence and status pulses.
module spi_sector_poller_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 40000;
    localparam int POLL_HZ    = 10;
    localparam int POLL_CYC   = CLK_HZ / POLL_HZ;
    localparam int SCK_HALF   = 2;
    localparam int CS_GAP     = 6;
    localparam int SECTOR     = 512;
    localparam int N_POLLS    = 8;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n;
    logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;
    logic fetch_req, fetch_ack, fetch_err;
    logic [23:0] xfer_sector;
    logic [7:0] src_data, snk_data;
    logic src_valid, src_ready, snk_valid, snk_ready;
    logic [31:0] status_word;
    logic status_chg;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sector_poller #(.CLK_HZ(CLK_HZ), .POLL_HZ(POLL_HZ), .SCK_HALF(SCK_HALF),
                        .CS_GAP(CS_GAP), .SECTOR_BYTES(SECTOR)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .fetch_req(fetch_req),
        .fetch_ack(fetch_ack), .fetch_err(fetch_err), .xfer_sector(xfer_sector),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
        .status_word(status_word), .status_chg(status_chg));

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Scripted status words, one per poll.
    function automatic logic [31:0] status_of(input int p);
        case (p)
            0: return 32'h000000A4;
            1: return 32'h000000A4;
            2: return 32'h123456A5;
            3: return 32'h123456A5;
            4: return 32'hABCDEFA6;
            5: return 32'h000001A7;
            6: return 32'hFFFFFFFF;
            default: return 32'h000000A4;
        endcase
    endfunction

    function automatic logic [7:0] rd_pat(input int k, input int i);
        return 8'((i * 13 + k * 7 + 5) & 255);
    endfunction

    function automatic logic [7:0] wr_pat(input int i);
        return 8'(((i * 29 + 60) ^ (i >> 3)) & 255);
    endfunction

    // Reference state
    int cyc = 0;
    bit started = 0;
    bit all_done = 0;
    int end_wait = -1;
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_freq = 1'b0;
    int hi_run = 0;
    int bitcnt = 0, byte_no = 0, fall_cyc = 0;
    logic [7:0] rx_sh = '0, tx_sh = '0, cur_cmd = '0;
    logic [7:0] tx_q[$];
    logic [7:0] exp_cmd = 8'h50;
    logic [31:0] prev_word = '0;
    int poll_no = 0;
    int poll_start[N_POLLS];
    bit exp_fetch = 0;
    logic [23:0] exp_sector = '0;
    bit plan_err = 0;
    int fdel = 0;
    int rd_k = 0, rd_bad = 0, src_idx = 0;
    int sink_idx = 0, sink_bad = 0;
    int clk_mism = 0;
    int rd_xfers = 0, wr_xfers = 0;

    initial begin
        rst_n = 1'b0;
        spi_miso = 1'b0; fetch_ack = 1'b0; fetch_err = 1'b0;
        src_data = '0; src_valid = 1'b0; snk_ready = 1'b0;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(spi_cs_n == 1'b1, "R10", "cs_n in reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R10", "sclk in reset", spi_sclk, 0);
        check(spi_mosi == 1'b0, "R10", "mosi in reset", spi_mosi, 0);
        check(fetch_req == 1'b0, "R10", "fetch_req in reset", fetch_req, 0);
        check(snk_valid == 1'b0, "R10", "snk_valid in reset", snk_valid, 0);
        check(status_chg == 1'b0, "R10", "status_chg in reset", status_chg, 0);
        check(status_word == 32'h0, "R10", "status_word in reset", status_word, 0);
        rst_n = 1'b1;
        started = 1;
        while (!all_done && cyc < WATCHDOG) @(negedge clk);
        if (!all_done) check(0, "WATCHDOG", "run did not complete", cyc, WATCHDOG);
        check(poll_no == N_POLLS, "R1", "polls seen", poll_no, N_POLLS);
        check(rd_xfers == 2, "R7", "sector read-outs", rd_xfers, 2);
        check(wr_xfers == 1, "R8", "sector write-ins", wr_xfers, 1);
        check(clk_mism == 0, "R9", "per-clock mismatches", clk_mism, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Per-clock reference: SPI slave, storage models and comparisons.
    initial forever begin
        @(negedge clk);
        if (started) begin
            bit cs_fall, cs_rise, poll_end;
            cyc++;
            cs_fall  = prev_cs && !spi_cs_n;
            cs_rise  = !prev_cs && spi_cs_n;
            poll_end = 0;

            if (cs_fall) begin
                // R9 deselect gap before every transaction
                check(hi_run >= CS_GAP, "R9", "select high gap", hi_run, CS_GAP);
                bitcnt = 0; byte_no = 0; tx_q.delete();
                spi_miso = 1'b0; tx_sh = '0; fall_cyc = cyc;
            end

            if (!spi_cs_n && !cs_fall) begin
                if (!prev_sclk && spi_sclk) begin
                    rx_sh = {rx_sh[6:0], spi_mosi};
                    bitcnt++;
                    if (bitcnt % 8 == 0) begin
                        if (byte_no == 0) begin
                            cur_cmd = rx_sh;
                            // R2 R5 R6 command byte matches the predicted transaction
                            check(rx_sh == exp_cmd, "R5", "command byte", rx_sh, exp_cmd);
                            if (rx_sh == 8'h50) begin
                                logic [31:0] s;
                                s = status_of(poll_no);
                                if (poll_no < N_POLLS) poll_start[poll_no] = fall_cyc;
                                tx_q.push_back(s[31:24]); tx_q.push_back(s[23:16]);
                                tx_q.push_back(s[15:8]);  tx_q.push_back(s[7:0]);
                            end else if (rx_sh == 8'h52) begin
                                for (int i = 0; i < SECTOR; i++) tx_q.push_back(wr_pat(i));
                                sink_idx = 0; sink_bad = 0;
                            end else if (rx_sh == 8'h51) begin
                                rd_bad = 0;
                            end
                        end else if (cur_cmd == 8'h51) begin
                            if (rx_sh != rd_pat(rd_k, byte_no - 1)) rd_bad++;
                        end
                        byte_no++;
                    end
                end else if (prev_sclk && !spi_sclk) begin
                    if (bitcnt % 8 == 0) begin
                        logic [7:0] b;
                        b = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
                        spi_miso = b[7]; tx_sh = {b[6:0], 1'b0};
                    end else begin
                        spi_miso = tx_sh[7]; tx_sh = {tx_sh[6:0], 1'b0};
                    end
                end
            end

            if (cs_rise) begin
                if (cur_cmd == 8'h50) begin
                    logic [31:0] s;
                    bit sig, exp_chg;
                    poll_end = 1;
                    s = status_of(poll_no);
                    check(byte_no == 5, "R2", "poll frame bytes", byte_no, 5);
                    check(status_word == s, "R3", "status word", status_word, s);
                    exp_chg = (s != prev_word);
                    check(status_chg == exp_chg, "R4", "status change pulse", status_chg, exp_chg);
                    prev_word = s;
                    sig = (s[7:2] == 6'b101001);
                    if (sig && s[0]) begin
                        exp_fetch = 1; exp_sector = s[31:8];
                        plan_err = (poll_no == 2);
                        exp_cmd = plan_err ? 8'h50 : 8'h51;
                    end else if (sig && s[1]) begin
                        exp_cmd = 8'h52;
                    end else begin
                        exp_cmd = 8'h50;
                    end
                    if (poll_no == 2) begin
                        // R1 poll spacing while idle
                        check(poll_start[1] - poll_start[0] == POLL_CYC, "R1", "poll interval 0-1",
                              poll_start[1] - poll_start[0], POLL_CYC);
                        check(poll_start[2] - poll_start[1] == POLL_CYC, "R1", "poll interval 1-2",
                              poll_start[2] - poll_start[1], POLL_CYC);
                    end
                    poll_no++;
                    if (poll_no == N_POLLS) end_wait = 20;
                end else if (cur_cmd == 8'h51) begin
                    // R7 all sector bytes, in order
                    check(byte_no == SECTOR + 1, "R7", "read-out byte count", byte_no, SECTOR + 1);
                    check(rd_bad == 0, "R7", "read-out byte mismatches", rd_bad, 0);
                    rd_k++; rd_xfers++; exp_cmd = 8'h50;
                end else if (cur_cmd == 8'h52) begin
                    // R8 all slave bytes reach the sink in order
                    check(sink_idx == SECTOR, "R8", "sink byte count", sink_idx, SECTOR);
                    check(sink_bad == 0, "R8", "sink byte mismatches", sink_bad, 0);
                    wr_xfers++; exp_cmd = 8'h50;
                end
            end

            // R4 no pulse outside a poll end; R9 clock idle while deselected
            if (!poll_end && status_chg) begin
                clk_mism++;
                check(0, "R4", "status_chg outside poll end", status_chg, 0);
            end
            if (spi_cs_n && spi_sclk) begin
                clk_mism++;
                check(0, "R9", "sclk while deselected", spi_sclk, 0);
            end

            // Storage fetch model (R6)
            if (fetch_ack) begin
                fetch_ack = 1'b0; fetch_err = 1'b0;
            end else if (fetch_req) begin
                if (!prev_freq) begin
                    check(exp_fetch, "R6", "fetch request expected", fetch_req, exp_fetch);
                    check(xfer_sector == exp_sector, "R6", "fetch sector", xfer_sector, exp_sector);
                    exp_fetch = 0; fdel = 0;
                end
                fdel++;
                if (fdel == 6) begin
                    fetch_ack = 1'b1; fetch_err = plan_err;
                end
            end

            // Byte source with gaps (R7)
            src_valid = 1'b0;
            if (src_ready && (cyc % 4 != 1)) begin
                src_valid = 1'b1;
                src_data = rd_pat(rd_k, src_idx);
                src_idx++;
            end
            if (cs_fall) src_idx = 0;

            // Byte sink with stalls (R8)
            snk_ready = (cyc % 3 != 0);
            if (snk_valid && snk_ready) begin
                if (snk_data != wr_pat(sink_idx)) sink_bad++;
                sink_idx++;
            end

            if (spi_cs_n) hi_run++; else hi_run = 0;
            prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_freq = fetch_req;

            if (end_wait > 0) begin
                end_wait--;
                if (end_wait == 0) all_done = 1;
            end
        end
    end

endmodule